// File: doc/BRIEF.md
# TDM Discrete-Sync RGB565 Video Formatter

This block sits at the edge of a display pipeline and turns a stream of RGB565 pixels, with their horizontal sync, vertical sync, field-ID and data-enable strobes, into a 16-bit parallel bus with discrete sync outputs. It feeds a standard-definition video encoder. The encoder samples on a 27 MHz clock, but pixels are produced at only 13.5 MHz. With time-division mode on, the block spends two output clocks on each pixel. The first clock carries the pixel. The second is a filler cycle in which the bus keeps its previous value.

Upstream offers a pixel and its strobes on every clock. It advances to a new pixel only when the ready output is high. In time-division mode that happens every second clock, and the cadence restarts on each rising edge of data-enable. With time-division mode off, ready stays high and the block passes one pixel per clock.

The source aligns the field-ID toggle with an edge of horizontal sync. Some receivers only detect a field-ID change while horizontal sync is active, so the field-ID output goes through a delay line whose extra depth (0 to 3 clocks) is chosen by an input. All other outputs share a single register stage, so they stay aligned with each other.

Top module: `tdm_rgb_formatter`

## Requirements
- R1: The output bus packs the colour inputs as out_data[4:0] = red, out_data[10:5] = green and out_data[15:11] = blue. A pixel accepted at a clock edge appears on out_data right after that edge, which is one clock of latency.
- R2: With tdm_en low, in_ready is high on every cycle and a new pixel is loaded on every clock.
- R3: With tdm_en high and in_de steady, in_ready alternates between high (first, data cycle) and low (second, filler cycle). The pixel present on a high-ready cycle is loaded at that clock edge.
- R4: At the clock edge that ends a filler cycle (in_ready low), out_data keeps its previous value, whatever the colour inputs are.
- R5: A cycle in which in_de is high and was low in the previous cycle is always a data cycle (in_ready high), whatever the previous phase was. The first cycle after reset counts as following a cycle with in_de low.
- R6: out_hs, out_vs and out_de equal in_hs, in_vs and in_de delayed by exactly one clock, on filler cycles as well.
- R7: out_fid equals in_fid delayed by 1 + fid_dly clocks, where fid_dly ranges from 0 to 3. Delay stages that have not yet been filled since reset read as 0.
- R8: A clock edge with rst_n low clears out_data, out_hs, out_vs, out_de, out_fid, the whole field-ID delay line and the phase state. The first cycle after reset is a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock (27 MHz in time-division use) |
| rst_n | input | 1 | Synchronous reset, active low |
| tdm_en | input | 1 | 1 = two clocks per pixel, 0 = one clock per pixel |
| fid_dly | input | 2 | Extra field-ID delay in clocks, 0 to 3 |
| in_red | input | 5 | Red component of the offered pixel |
| in_green | input | 6 | Green component of the offered pixel |
| in_blue | input | 5 | Blue component of the offered pixel |
| in_hs | input | 1 | Horizontal sync strobe |
| in_vs | input | 1 | Vertical sync strobe |
| in_fid | input | 1 | Field identifier |
| in_de | input | 1 | Data enable |
| in_ready | output | 1 | High on cycles where the offered pixel is taken |
| out_data | output | 16 | Packed RGB565 output bus |
| out_hs | output | 1 | Registered horizontal sync |
| out_vs | output | 1 | Registered vertical sync |
| out_de | output | 1 | Registered data enable |
| out_fid | output | 1 | Field identifier after the programmable delay |

## Verification
The bench goes through every value of all three colour fields in both modes. A design that crossed or shifted a field would put the wrong bits on the bus. During filler cycles it drives different colours, and a design that reloaded there would show the filler value instead of holding the pixel. The data-enable pattern has a period of 37 clocks, so the rising edge falls on both phases. A design that let the toggle run freely would report ready low on half of those rising edges. The field-ID input is driven with a varying pattern at every delay setting and directly after reset, which exposes an off-by-one in the tap selection and any stage that reset does not clear.

// File: rtl/tdm_fmt_pkg.sv
// Package: shared widths and the RGB565 packing rule for the formatter.
// Assumes 5/6/5 colour components and a 16-bit bus.
package tdm_fmt_pkg;
    parameter int RED_W   = 5;
    parameter int GREEN_W = 6;
    parameter int BLUE_W  = 5;
    localparam int BUS_W  = RED_W + GREEN_W + BLUE_W;

    // Place red in the low bits, green in the middle, blue at the top.
    function automatic logic [BUS_W-1:0] pack565(input logic [RED_W-1:0]   r,
                                                 input logic [GREEN_W-1:0] g,
                                                 input logic [BLUE_W-1:0]  b);
        return {b, g, r};
    endfunction
endpackage

// File: rtl/tdm_phase_ctrl.sv
// Module: tdm_phase_ctrl
// Tracks whether the current clock is the data cycle or the filler cycle
// of a pixel. In time-division mode the phase toggles every clock and is
// forced back to the data cycle when data-enable rises. Assumes in_de is
// registered upstream, so in_ready may depend on it combinationally.
module tdm_phase_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tdm_en,
    input  logic in_de,
    output logic first_phase,
    output logic in_ready
);
    logic de_prev;
    logic second_q;
    logic de_rise;

    // Decide the phase of the current cycle from the state and the DE edge.
    always_comb begin
        de_rise     = in_de & ~de_prev;
        first_phase = ~(tdm_en & second_q & ~de_rise);
        in_ready    = first_phase;
    end

    // Advance the phase toggle and remember data-enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_prev  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            de_prev  <= in_de;
            second_q <= tdm_en & first_phase;
        end
    end

    AST_DISABLED_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !tdm_en |-> in_ready); // R2
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tdm_en && in_ready) |=> (!in_ready || !tdm_en || (in_de && !$past(in_de)))); // R3
    AST_FILLER_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (tdm_en && !in_ready) |=> in_ready); // R3
endmodule

// File: rtl/tdm_data_stage.sv
// Module: tdm_data_stage
// Single output register stage for the packed pixel and the line/frame
// strobes. The pixel is loaded only on data cycles; the strobes pass
// every clock so that all outputs share one clock of latency.
module tdm_data_stage
    import tdm_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RED_W-1:0]   in_red,
    input  logic [GREEN_W-1:0] in_green,
    input  logic [BLUE_W-1:0]  in_blue,
    input  logic               in_hs,
    input  logic               in_vs,
    input  logic               in_de,
    output logic [BUS_W-1:0]   out_data,
    output logic               out_hs,
    output logic               out_vs,
    output logic               out_de
);
    // Register the strobes every clock and the pixel on data cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_hs   <= 1'b0;
            out_vs   <= 1'b0;
            out_de   <= 1'b0;
        end else begin
            out_hs <= in_hs;
            out_vs <= in_vs;
            out_de <= in_de;
            if (load) begin
                out_data <= pack565(in_red, in_green, in_blue);
            end
        end
    end

    AST_RED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_data[RED_W-1:0] == $past(in_red)); // R1
    AST_BLUE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_data[BUS_W-1:BUS_W-BLUE_W] == $past(in_blue)); // R1
    AST_FILLER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_data)); // R4
    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_hs == $past(in_hs) && out_vs == $past(in_vs) && out_de == $past(in_de))); // R6
endmodule

// File: rtl/fid_delay_line.sv
// Module: fid_delay_line
// Shift register for the field identifier. Tap 0 is aligned with the
// other registered outputs; the select picks how many further clocks of
// delay are added. Assumes the select is quasi-static during a field.
module fid_delay_line #(
    parameter int MAX_DLY = 3,
    localparam int SEL_W  = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fid_in,
    input  logic [SEL_W-1:0] sel,
    output logic             fid_out
);
    logic [MAX_DLY:0] tap;

    // First stage: aligned with the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) tap[0] <= 1'b0;
        else        tap[0] <= fid_in;
    end

    for (genvar i = 1; i <= MAX_DLY; i++) begin : g_stage
        // Extra stage i of the field-ID delay.
        always_ff @(posedge clk) begin
            if (!rst_n) tap[i] <= 1'b0;
            else        tap[i] <= tap[i-1];
        end

        AST_FID_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> tap[i] == $past(tap[i-1])); // R7
    end

    // Pick the tap, clamping selects beyond the deepest stage.
    always_comb begin
        if (int'(sel) > MAX_DLY) fid_out = tap[MAX_DLY];
        else                     fid_out = tap[sel];
    end

    AST_FID_TAP0: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> (sel != '0) || (fid_out == $past(fid_in))); // R7
endmodule

// File: rtl/tdm_rgb_formatter.sv
// Module: tdm_rgb_formatter
// Top of the formatter: the phase control, the output register stage and
// the field-ID delay line. Assumes upstream holds a pixel until in_ready
// is seen high and that the strobes are valid on every clock.
module tdm_rgb_formatter
    import tdm_fmt_pkg::*;
#(
    parameter int FID_MAX_DLY = 3,
    localparam int DLY_W      = (FID_MAX_DLY < 1) ? 1 : $clog2(FID_MAX_DLY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tdm_en,
    input  logic [DLY_W-1:0]   fid_dly,
    input  logic [RED_W-1:0]   in_red,
    input  logic [GREEN_W-1:0] in_green,
    input  logic [BLUE_W-1:0]  in_blue,
    input  logic               in_hs,
    input  logic               in_vs,
    input  logic               in_fid,
    input  logic               in_de,
    output logic               in_ready,
    output logic [BUS_W-1:0]   out_data,
    output logic               out_hs,
    output logic               out_vs,
    output logic               out_de,
    output logic               out_fid
);
    logic first_phase;

    tdm_phase_ctrl u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tdm_en      (tdm_en),
        .in_de       (in_de),
        .first_phase (first_phase),
        .in_ready    (in_ready)
    );

    tdm_data_stage u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (first_phase),
        .in_red   (in_red),
        .in_green (in_green),
        .in_blue  (in_blue),
        .in_hs    (in_hs),
        .in_vs    (in_vs),
        .in_de    (in_de),
        .out_data (out_data),
        .out_hs   (out_hs),
        .out_vs   (out_vs),
        .out_de   (out_de)
    );

    fid_delay_line #(.MAX_DLY(FID_MAX_DLY)) u_fid (
        .clk     (clk),
        .rst_n   (rst_n),
        .fid_in  (in_fid),
        .sel     (fid_dly),
        .fid_out (out_fid)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_data == '0 && !out_hs && !out_vs && !out_de && !out_fid)); // R8
    AST_RISE_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_de && !$past(in_de)) |-> in_ready); // R5
endmodule

// File: tb/tdm_rgb_formatter_bench.sv
module tdm_rgb_formatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdm_en = 1'b0;
    logic [1:0]  fid_dly = 2'd0;
    logic [4:0]  in_red = '0;
    logic [5:0]  in_green = '0;
    logic [4:0]  in_blue = '0;
    logic        in_hs = 1'b0, in_vs = 1'b0, in_fid = 1'b0, in_de = 1'b0;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_hs, out_vs, out_de, out_fid;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state derived from the requirements
    logic [15:0] exp_data = '0;
    logic        exp_hs = 0, exp_vs = 0, exp_de = 0;
    logic        m_second = 0, m_prev_de = 0;
    logic [4:0]  fid_hist = '0;

    always #5 clk = ~clk;

    tdm_rgb_formatter u_tdm_rgb_formatter (
        .clk(clk), .rst_n(rst_n), .tdm_en(tdm_en), .fid_dly(fid_dly),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .in_hs(in_hs), .in_vs(in_vs), .in_fid(in_fid), .in_de(in_de),
        .in_ready(in_ready), .out_data(out_data), .out_hs(out_hs),
        .out_vs(out_vs), .out_de(out_de), .out_fid(out_fid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One clock: drive at negedge, check ready, clock, check outputs.
    task automatic cyc(input logic tdm, input logic [1:0] dly,
                       input logic [4:0] r, input logic [5:0] g, input logic [4:0] b,
                       input logic hs, input logic vs, input logic fid, input logic de);
        logic rise, filler;
        tdm_en = tdm; fid_dly = dly;
        in_red = r; in_green = g; in_blue = b;
        in_hs = hs; in_vs = vs; in_fid = fid; in_de = de;
        rise   = de & ~m_prev_de;
        filler = tdm & m_second & ~rise;
        #1;
        if (rise && tdm) chk("R5 ready on DE rise", {15'd0, in_ready}, 16'd1);
        else if (tdm)    chk("R3 ready phase", {15'd0, in_ready}, {15'd0, ~filler});
        else             chk("R2 ready held", {15'd0, in_ready}, 16'd1);
        @(posedge clk);
        if (!filler) exp_data = {b, g, r};
        m_second  = tdm & ~filler;
        m_prev_de = de;
        exp_hs = hs; exp_vs = vs; exp_de = de;
        fid_hist = {fid_hist[3:0], fid};
        @(negedge clk);
        if (filler)   chk("R4 filler hold", out_data, exp_data);
        else if (tdm) chk("R3 tdm data", out_data, exp_data);
        else          chk("R1 packing", out_data, exp_data);
        chk("R6 sync align", {13'd0, out_hs, out_vs, out_de}, {13'd0, exp_hs, exp_vs, exp_de});
        chk("R7 fid delay", {15'd0, out_fid}, {15'd0, fid_hist[dly]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_red = '1; in_green = '1; in_blue = '1;
        in_hs = 1; in_vs = 1; in_fid = 1; in_de = 1; tdm_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset data", out_data, 16'h0000);
        chk("R8 reset strobes", {12'd0, out_hs, out_vs, out_de, out_fid}, 16'd0);
        exp_data = '0; m_second = 0; m_prev_de = 0; fid_hist = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 R2: every field value, one pixel per clock
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] w;
            w = 11'(v);
            cyc(1'b0, 2'(v / 512), w[4:0], w[10:5], w[10:6] ^ 5'h15,
                w[3], w[7], w[2] ^ w[5], (v % 37) != 0);
        end
        do_reset();
        // R3 R4 R5: two clocks per pixel, filler cycles carry garbage colours
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] w;
            logic        de, rise, filler;
            w = 11'(v);
            de = (v % 37) != 0;
            rise = de & ~m_prev_de;
            filler = m_second & ~rise;
            if (filler)
                cyc(1'b1, 2'(v / 512), ~w[4:0], ~w[10:5], w[4:0], w[3], w[7], w[2] ^ w[5], de);
            else
                cyc(1'b1, 2'(v / 512), w[4:0], w[10:5], w[10:6] ^ 5'h15, w[3], w[7], w[2] ^ w[5], de);
        end
        // R7: field-ID pattern at every delay, each starting right after reset
        for (int d = 0; d < 4; d++) begin
            do_reset();
            for (int k = 0; k < 64; k++) begin
                logic [6:0] p;
                p = 7'(k * 13 + d);
                cyc(1'b0, 2'(d), p[4:0], 6'(k), 5'(d), p[0], p[1], p[3] ^ p[6], 1'b1);
            end
        end
        // R2: leave time-division mode mid-line, next cycle must load
        do_reset();
        cyc(1'b1, 2'd2, 5'd1, 6'd2, 5'd3, 0, 0, 1, 1);
        cyc(1'b0, 2'd2, 5'd9, 6'd9, 5'd9, 0, 0, 1, 1);
        cyc(1'b0, 2'd2, 5'd7, 6'd7, 5'd7, 0, 0, 0, 1);
        finish_run();
    end
endmodule